// File: doc/BRIEF.md
# Call and Return Stack Controller

This block keeps the program counter and the stack pointer of a small processor core and runs a last-in-first-out stack on a private synchronous RAM. It serves five kinds of request: a plain data push, a plain data pop, a subroutine call, a subroutine return, and a sequential step that moves the program counter on by one instruction. Instruction fetch and decode sit outside the block. They drive the request strobes and read back the program counter.

The stack grows toward lower byte addresses and is word-sized. A push moves the stack pointer down by two and then writes. A pop reads the slot at the stack pointer and then moves the pointer up by two. The program counter already points at the instruction after the call when a call arrives. The call runs in two ordered steps: it saves that value on the stack, then it jumps to the entry address. A return reads the saved address back into the program counter. Calls and returns hold `busy` high for one cycle, and no request is taken in that cycle. Overflow and underflow are refused and raise a sticky error flag.

Top module: `crs_call_stack`

## Requirements
- R1: After a synchronous active-low reset, `pc` is `RESET_PC` (0x0100), `sp` is `STACK_TOP` (0x0400), `busy` is 0, `stack_err` is 0 and `pop_data` is 0.
- R2: An accepted push lowers `sp` by 2 on the request edge and stores `push_data` in the slot the new `sp` addresses.
- R3: An accepted pop places the most recently stored and not yet popped word on `pop_data` and raises `sp` by 2, both on the request edge. The value on `pop_data` holds until the next pop or return.
- R4: A `pc_step` request adds `INSTR_BYTES` (2) to `pc`.
- R5: An accepted call stores the current `pc` at `sp-2` and lowers `sp` by 2 on the request edge. `busy` is then high for one cycle, and on the following edge `pc` takes the `entry_addr` that was sampled with the request.
- R6: An accepted return raises `sp` by 2 and shows the top word on `pop_data` on the request edge. `busy` is then high for one cycle, and on the following edge `pc` takes that word.
- R7: When several requests arrive together, only one is acted on, in the order call, return, push, pop, step.
- R8: Every request presented while `busy` is high is ignored. `sp`, `pc` and the stack contents are left as they were.
- R9: A push or call with the stack full (`sp` = `STACK_TOP`-2·`DEPTH`), or a pop or return with it empty (`sp` = `STACK_TOP`), leaves `sp`, `pc`, `pop_data` and the stack contents unchanged. It sets `stack_err`, which stays set until reset.
- R10: `sp` is always even and lies between `STACK_TOP`-2·`DEPTH` and `STACK_TOP`. The stack holds exactly `DEPTH` (8) words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| push_req | input | 1 | Push `push_data` onto the stack |
| pop_req | input | 1 | Pop the top word onto `pop_data` |
| call_req | input | 1 | Call the subroutine at `entry_addr` |
| ret_req | input | 1 | Return from the subroutine |
| pc_step | input | 1 | Advance `pc` by one instruction |
| entry_addr | input | AW | Subroutine entry address for a call |
| push_data | input | AW | Word to push |
| pop_data | output | AW | Word read by the latest pop or return |
| pc | output | AW | Program counter |
| sp | output | AW | Stack pointer, a byte address |
| busy | output | 1 | Second step of a call or return in progress |
| stack_err | output | 1 | Sticky overflow or underflow flag |

## Verification
The bench fills the stack to all eight slots and then tries a ninth push. A design that checked fullness one slot late would overwrite a word below the stack region, and the LIFO drain that follows would return a wrong value. Nested calls go all eight deep, and the returns then unwind in reverse. A call that jumped before saving, or saved the address of the call itself, would bring back the wrong program counter. The bench presents requests in the busy cycle and presents several requests together. A design that leaked a step or a push through the busy cycle, or that ranked the requests differently, shows a wrong `pc` or `sp`. Underflow by pop and by return checks that a refused read leaves `pop_data` and `pc` untouched.

// File: rtl/crs_pkg.sv
// Shared types for the call and return stack controller.
// Assumes: one accepted operation per cycle at most.
package crs_pkg;
    typedef enum logic [2:0] {
        OP_NONE,
        OP_STEP,
        OP_PUSH,
        OP_POP,
        OP_CALL,
        OP_RET
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CALL_JMP,
        ST_RET_LOAD
    } st_e;
endpackage

// File: rtl/crs_arbiter.sv
// Request arbiter: picks at most one request per cycle by fixed priority
// (call, return, push, pop, step) and flags overflow or underflow.
// Assumes: the fullness and emptiness inputs reflect the current stack pointer.
module crs_arbiter
    import crs_pkg::*;
(
    input  logic busy,
    input  logic empty,
    input  logic full,
    input  logic call_req,
    input  logic ret_req,
    input  logic push_req,
    input  logic pop_req,
    input  logic step_req,
    output op_e  op,
    output logic fault
);
    // Priority selection with the bound check folded in.
    always_comb begin
        op    = OP_NONE;
        fault = 1'b0;
        if (!busy) begin
            if (call_req) begin
                if (full) fault = 1'b1;
                else      op    = OP_CALL;
            end else if (ret_req) begin
                if (empty) fault = 1'b1;
                else       op    = OP_RET;
            end else if (push_req) begin
                if (full) fault = 1'b1;
                else      op    = OP_PUSH;
            end else if (pop_req) begin
                if (empty) fault = 1'b1;
                else       op    = OP_POP;
            end else if (step_req) begin
                op = OP_STEP;
            end
        end
    end
endmodule

// File: rtl/crs_sp.sv
// Stack pointer unit: a downward-growing byte pointer stepping by 2. It
// produces the full and empty flags and the RAM slot indices for a write at
// sp-2 and a read at sp.
// Assumes: DEPTH is a power of two and the region sits below STACK_TOP.
module crs_sp #(
    parameter int AW        = 16,
    parameter int DEPTH     = 8,
    parameter int STACK_TOP = 'h0400,
    parameter int IDX_W     = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec,
    input  logic             inc,
    output logic [AW-1:0]    sp,
    output logic             empty,
    output logic             full,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] rd_idx
);
    localparam logic [AW-1:0] TOP  = AW'(STACK_TOP);
    localparam logic [AW-1:0] BASE = AW'(STACK_TOP - 2 * DEPTH);
    localparam logic [AW-1:0] TWO  = AW'(2);

    // Pointer register: predecrement on write, postincrement on read.
    always_ff @(posedge clk) begin
        if (!rst_n)   sp <= TOP;
        else if (dec) sp <= sp - TWO;
        else if (inc) sp <= sp + TWO;
    end

    // Bound flags and word indices into the stack RAM.
    always_comb begin
        empty  = (sp == TOP);
        full   = (sp == BASE);
        wr_idx = IDX_W'((sp - BASE - TWO) >> 1);
        rd_idx = IDX_W'((sp - BASE) >> 1);
    end
endmodule

// File: rtl/crs_ram.sv
// Stack storage: single-clock RAM with a synchronous write and a registered read.
// Assumes: the write and read enables never address the same slot in one cycle.
module crs_ram #(
    parameter int AW    = 16,
    parameter int DEPTH = 8,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [AW-1:0]    wdata,
    input  logic             re,
    input  logic [IDX_W-1:0] ridx,
    output logic [AW-1:0]    rdata
);
    logic [AW-1:0] mem [DEPTH];

    // Array write; contents need no reset.
    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end

    // Registered read port, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[ridx];
    end
endmodule

// File: rtl/crs_call_stack.sv
// Call and return stack controller top. It owns the program counter, the
// two-step call and return sequencer and the sticky error flag, and it joins
// the arbiter, the pointer unit and the stack RAM.
// Assumes: the request strobes are synchronous to clk and last one cycle each.
module crs_call_stack
    import crs_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DEPTH       = 8,
    parameter int STACK_TOP   = 'h0400,
    parameter int RESET_PC    = 'h0100,
    parameter int INSTR_BYTES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic          pop_req,
    input  logic          call_req,
    input  logic          ret_req,
    input  logic          pc_step,
    input  logic [AW-1:0] entry_addr,
    input  logic [AW-1:0] push_data,
    output logic [AW-1:0] pop_data,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] sp,
    output logic          busy,
    output logic          stack_err
);
    localparam int IDX_W = $clog2(DEPTH);

    st_e              state;
    op_e              op;
    logic             fault;
    logic             empty;
    logic             full;
    logic             sp_dec;
    logic             sp_inc;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [AW-1:0]    wr_word;
    logic [AW-1:0]    target_q;

    assign busy = (state != ST_IDLE);

    crs_arbiter u_arb (
        .busy     (busy),
        .empty    (empty),
        .full     (full),
        .call_req (call_req),
        .ret_req  (ret_req),
        .push_req (push_req),
        .pop_req  (pop_req),
        .step_req (pc_step),
        .op       (op),
        .fault    (fault)
    );

    // Stack movement and the word written for the chosen operation.
    always_comb begin
        sp_dec  = (op == OP_PUSH) || (op == OP_CALL);
        sp_inc  = (op == OP_POP)  || (op == OP_RET);
        wr_word = (op == OP_CALL) ? pc : push_data;
    end

    crs_sp #(
        .AW        (AW),
        .DEPTH     (DEPTH),
        .STACK_TOP (STACK_TOP),
        .IDX_W     (IDX_W)
    ) u_sp (
        .clk    (clk),
        .rst_n  (rst_n),
        .dec    (sp_dec),
        .inc    (sp_inc),
        .sp     (sp),
        .empty  (empty),
        .full   (full),
        .wr_idx (wr_idx),
        .rd_idx (rd_idx)
    );

    crs_ram #(
        .AW    (AW),
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (sp_dec),
        .widx  (wr_idx),
        .wdata (wr_word),
        .re    (sp_inc),
        .ridx  (rd_idx),
        .rdata (pop_data)
    );

    // Sequencer: the second step of a call or return runs in the busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (op == OP_CALL)     state <= ST_CALL_JMP;
                    else if (op == OP_RET) state <= ST_RET_LOAD;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Entry address capture for the jump step.
    always_ff @(posedge clk) begin
        if (!rst_n)              target_q <= '0;
        else if (op == OP_CALL)  target_q <= entry_addr;
    end

    // Program counter: step, jump to the entry, or restore from the stack.
    always_ff @(posedge clk) begin
        if (!rst_n)                      pc <= AW'(RESET_PC);
        else if (state == ST_CALL_JMP)   pc <= target_q;
        else if (state == ST_RET_LOAD)   pc <= pop_data;
        else if (op == OP_STEP)          pc <= pc + AW'(INSTR_BYTES);
    end

    // Sticky overflow and underflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n)     stack_err <= 1'b0;
        else if (fault) stack_err <= 1'b1;
    end
endmodule

// File: rtl/crs_call_stack_chk.sv
// Port-level property checker for crs_call_stack, attached by bind.
// Assumes: the same parameter values as the instance it is bound to.
module crs_call_stack_chk #(
    parameter int AW        = 16,
    parameter int DEPTH     = 8,
    parameter int STACK_TOP = 'h0400
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_req,
    input logic          call_req,
    input logic          ret_req,
    input logic [AW-1:0] entry_addr,
    input logic [AW-1:0] pop_data,
    input logic [AW-1:0] pc,
    input logic [AW-1:0] sp,
    input logic          busy,
    input logic          stack_err
);
    localparam logic [AW-1:0] TOP_A  = AW'(STACK_TOP);
    localparam logic [AW-1:0] BASE_A = AW'(STACK_TOP - 2 * DEPTH);

    a_r2_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !call_req && !ret_req && !busy && sp != BASE_A)
        |=> (sp == $past(sp) - AW'(2)));

    a_r5_call_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && !busy && sp != BASE_A)
        |=> busy ##1 (!busy && pc == $past(entry_addr, 2)));

    a_r6_ret_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !call_req && !busy && sp != TOP_A)
        |=> busy ##1 (pc == $past(pop_data)));

    a_r8_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    a_r8_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (sp == $past(sp)));

    a_r9_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((push_req || call_req) && !ret_req && !busy && sp == BASE_A)
        |=> (sp == $past(sp) && stack_err));

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stack_err |=> stack_err);

    a_r10_sp_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (sp >= BASE_A && sp <= TOP_A && !sp[0]));
endmodule

bind crs_call_stack crs_call_stack_chk #(
    .AW        (AW),
    .DEPTH     (DEPTH),
    .STACK_TOP (STACK_TOP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_req   (push_req),
    .call_req   (call_req),
    .ret_req    (ret_req),
    .entry_addr (entry_addr),
    .pop_data   (pop_data),
    .pc         (pc),
    .sp         (sp),
    .busy       (busy),
    .stack_err  (stack_err)
);

// File: tb/crs_call_stack_bench.sv
module crs_call_stack_bench;
    localparam int AW    = 16;
    localparam int DEPTH = 8;
    localparam logic [15:0] TOP = 16'h0400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push_req = 1'b0, pop_req = 1'b0, call_req = 1'b0, ret_req = 1'b0, pc_step = 1'b0;
    logic [15:0] entry_addr = '0, push_data = '0;
    logic [15:0] pop_data, pc, sp;
    logic busy, stack_err;

    int total = 0;
    int failed = 0;
    bit done = 1'b0;

    logic [15:0] mstk [DEPTH];
    int          mdepth;
    logic [15:0] pc_m;
    logic [15:0] last_pop;

    always #2 clk = ~clk;

    crs_call_stack #(.AW(AW), .DEPTH(DEPTH)) u_crs_call_stack (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
        .call_req(call_req), .ret_req(ret_req), .pc_step(pc_step),
        .entry_addr(entry_addr), .push_data(push_data), .pop_data(pop_data),
        .pc(pc), .sp(sp), .busy(busy), .stack_err(stack_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [15:0] exp_sp();
        return TOP - 16'(2 * mdepth);
    endfunction

    task automatic do_reset();
        {push_req, pop_req, call_req, ret_req, pc_step} = '0;
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        mdepth = 0;
        pc_m = 16'h0100;
        last_pop = 16'h0000;
        chk("R1 pc", pc, 16'h0100);
        chk("R1 sp", sp, TOP);
        chk("R1 busy", busy, 0);
        chk("R1 err", stack_err, 0);
        chk("R1 pop_data", pop_data, 0);
    endtask

    task automatic do_push(input logic [15:0] v);
        push_req = 1'b1;
        push_data = v;
        tick();
        push_req = 1'b0;
        if (mdepth < DEPTH) begin
            mstk[mdepth] = v;
            mdepth++;
            chk("R2 sp after push", sp, exp_sp());
        end else begin
            chk("R9 sp held on overflow", sp, exp_sp());
            chk("R9 err on overflow", stack_err, 1);
        end
    endtask

    task automatic do_pop();
        pop_req = 1'b1;
        tick();
        pop_req = 1'b0;
        if (mdepth > 0) begin
            mdepth--;
            last_pop = mstk[mdepth];
            chk("R3 pop_data LIFO", pop_data, last_pop);
            chk("R3 sp after pop", sp, exp_sp());
        end else begin
            chk("R9 sp held on underflow", sp, exp_sp());
            chk("R9 pop_data held", pop_data, last_pop);
            chk("R9 err on underflow", stack_err, 1);
        end
    endtask

    task automatic do_step();
        pc_step = 1'b1;
        tick();
        pc_step = 1'b0;
        pc_m = pc_m + 16'd2;
        chk("R4 pc step", pc, pc_m);
    endtask

    task automatic do_call(input logic [15:0] e);
        call_req = 1'b1;
        entry_addr = e;
        tick();
        call_req = 1'b0;
        if (mdepth < DEPTH) begin
            mstk[mdepth] = pc_m;
            mdepth++;
            chk("R5 busy in step two", busy, 1);
            chk("R5 sp after call", sp, exp_sp());
            tick();
            chk("R5 busy cleared", busy, 0);
            pc_m = e;
            chk("R5 pc at entry", pc, pc_m);
        end else begin
            chk("R9 no busy on full call", busy, 0);
            chk("R9 sp held on full call", sp, exp_sp());
            chk("R9 pc held on full call", pc, pc_m);
            chk("R9 err on full call", stack_err, 1);
        end
    endtask

    task automatic do_ret();
        ret_req = 1'b1;
        tick();
        ret_req = 1'b0;
        if (mdepth > 0) begin
            mdepth--;
            last_pop = mstk[mdepth];
            chk("R6 busy in step two", busy, 1);
            chk("R6 sp after return", sp, exp_sp());
            chk("R6 pop_data on return", pop_data, last_pop);
            tick();
            pc_m = last_pop;
            chk("R6 pc restored", pc, pc_m);
        end else begin
            chk("R9 no busy on empty return", busy, 0);
            chk("R9 pc held on empty return", pc, pc_m);
            chk("R9 err on empty return", stack_err, 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            failed++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R4: plain steps
        for (int i = 0; i < 3; i++) do_step();

        // R2, R3, R9, R10: fill, overflow, LIFO drain, underflow
        for (int i = 0; i < DEPTH; i++) begin
            do_push(16'hA000 + 16'(i * 16'h0111));
            chk("R2 no err while filling", stack_err, 0);
        end
        chk("R10 sp at lowest slot", sp, TOP - 16'(2 * DEPTH));
        do_push(16'hFFFF);
        for (int i = 0; i < DEPTH; i++) do_pop();
        chk("R10 sp back at top", sp, TOP);
        do_pop();
        chk("R9 err sticky", stack_err, 1);
        do_step();
        chk("R9 err stays set", stack_err, 1);

        // R5, R6, R9: nested calls eight deep, then unwind
        do_reset();
        for (int i = 0; i < DEPTH; i++) begin
            do_step();
            do_call(16'h2000 + 16'(i * 16'h0040));
        end
        do_call(16'h7000);
        for (int i = 0; i < DEPTH; i++) do_ret();
        chk("R6 pc back at first return", pc, 16'h0102);
        do_ret();

        // R7, R8: priority and busy-cycle masking
        do_reset();
        call_req = 1'b1; push_req = 1'b1; pop_req = 1'b1; pc_step = 1'b1;
        entry_addr = 16'h3000; push_data = 16'hBEEF;
        tick();
        call_req = 1'b0; pop_req = 1'b0;
        chk("R7 call wins busy", busy, 1);
        chk("R7 call wins sp", sp, TOP - 16'd2);
        tick();
        push_req = 1'b0; pc_step = 1'b0;
        chk("R8 step ignored while busy", pc, 16'h3000);
        chk("R8 push ignored while busy", sp, TOP - 16'd2);

        ret_req = 1'b1; push_req = 1'b1; pop_req = 1'b1; pc_step = 1'b1;
        tick();
        ret_req = 1'b0; push_req = 1'b0; pop_req = 1'b0; pc_step = 1'b0;
        chk("R7 return wins sp", sp, TOP);
        chk("R7 return wins data", pop_data, 16'h0100);
        tick();
        chk("R7 return restores pc", pc, 16'h0100);

        push_req = 1'b1; pop_req = 1'b1; pc_step = 1'b1; push_data = 16'h1234;
        tick();
        push_req = 1'b0; pop_req = 1'b0; pc_step = 1'b0;
        chk("R7 push over pop sp", sp, TOP - 16'd2);
        chk("R7 push over step pc", pc, 16'h0100);

        pop_req = 1'b1; pc_step = 1'b1;
        tick();
        pop_req = 1'b0; pc_step = 1'b0;
        chk("R7 pop over step data", pop_data, 16'h1234);
        chk("R7 pop over step pc", pc, 16'h0100);
        chk("R7 pop over step sp", sp, TOP);
        chk("R9 no err in priority run", stack_err, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule